// File: doc/BRIEF.md
# Receive Frame DMA with Buffer Chaining

This block sits between a line-side receiver and main memory. Frames arrive as a byte stream with start, end and error markers. Each frame is held in a small local queue first. Only a frame that ends cleanly is handed to the DMA engine. The engine then becomes bus master and copies the frame's bytes into the current host receive buffer.

When the last byte of a frame has been written, the engine reads a link word from the current buffer. That word is the address of the next free buffer, and it becomes the target for the following frame. The engine then raises a sticky interrupt to the host.

A frame that ends with the error flag set is thrown away, and so is a frame that overflows the queue. In either case the queue space is reclaimed, the bus stays quiet and no interrupt is raised. A link value of zero marks the end of the buffer chain. After that, reception pauses until the host loads a new buffer address.

Top module: `rx_chain_dma`

## Requirements
- R1: After reset `irq_o` and `bus_req_o` are low, and no buffer is loaded.
- R2: A frame is taken only if its first byte (`rx_valid_i` with `rx_sof_i`) arrives while `rx_en_i` is high and a buffer address is loaded; otherwise the whole frame is ignored.
- R3: Store and forward: no bus request is made for a frame before its end byte is accepted. Byte i of a good frame is written to word address `buf + DATA_OFS + i`, where `DATA_OFS` defaults to 1. The byte goes in bits [7:0] and the upper bits are zero.
- R4: After the last byte write, one read of `buf + LINK_OFS` (default offset 0) follows, and the value read becomes the next buffer address. `irq_o` goes high one edge after that read is granted. With constant grant and an L-byte frame whose end byte is sampled at edge E, the interrupt appears after edge E+L+2.
- R5: A frame whose end byte carries `rx_err_i`=1 causes no bus traffic and no interrupt. The next good frame lands in the same buffer.
- R6: The local queue holds DEPTH=16 bytes. A frame that would need a byte beyond that is dropped as in R5. A 16-byte frame that arrives with the queue empty is accepted.
- R7: A bus transfer completes in the cycle where `bus_req_o` and `bus_gnt_i` are both high, and read data is taken in that cycle. While the request waits for a grant, address, direction and write data hold steady.
- R8: A link value of zero ends the chain. Later frames are ignored and the bus stays idle until `base_load_i` supplies a new buffer.
- R9: `base_load_i` loads `base_addr_i` as the current buffer only while the DMA is idle (`bus_req_o` low). While the DMA is busy it is ignored.
- R10: `irq_o` stays high until `irq_clr_i` is seen. A new interrupt in the same cycle as a clear wins.
- R11: A start byte arriving inside an unfinished frame discards the partial bytes, and the new frame begins under the rule of R2.
- R12: Bytes with `rx_valid_i` high that arrive outside a frame and without `rx_sof_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receive enable, checked at frame start |
| base_load_i | input | 1 | Load a new current buffer address |
| base_addr_i | input | AW | Buffer address to load |
| rx_valid_i | input | 1 | Line byte valid |
| rx_data_i | input | 8 | Line byte |
| rx_sof_i | input | 1 | First byte of a frame |
| rx_eof_i | input | 1 | Last byte of a frame |
| rx_err_i | input | 1 | Frame error, valid with the end byte |
| bus_req_o | output | 1 | Bus mastership request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | AW | Word address |
| bus_wdata_o | output | AW | Write data |
| bus_rdata_i | input | AW | Read data, valid in the granted cycle |
| irq_o | output | 1 | Frame-received interrupt |
| irq_clr_i | input | 1 | Interrupt clear |

## Verification
With grant held high, the first byte write of a good frame is due on the second edge after the end byte. The writes then run one per edge, the link read follows, and the interrupt rises on the next edge. The timed check counts those edges and samples at the falling edge, so it sees the interrupt low one cycle before it is due and high on the cycle it is due. Under random grant, a good frame is judged by waiting up to 300 cycles for the interrupt and then comparing the buffer words. A dropped frame is judged after a 40-cycle quiet window, by the interrupt level, the request line and an untouched sentinel word in the buffer.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef struct packed {
    logic       last;
    logic [7:0] data;
  } rxd_ent_t;

  typedef enum logic [1:0] {
    DMA_IDLE = 2'd0,
    DMA_WR   = 2'd1,
    DMA_LNK  = 2'd2
  } dma_st_e;
endpackage

// File: rtl/rxd_fifo.sv
// Byte queue with a commit pointer; only committed entries are visible to the reader.
module rxd_fifo
  import rxd_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     restart_i,
  input  logic     discard_i,
  input  logic     push_i,
  input  rxd_ent_t ent_i,
  input  logic     commit_i,
  input  logic     pop_i,
  output rxd_ent_t ent_o,
  output logic     avail_o,
  output logic     full_o,
  output logic [PW:0] level_o
);
  localparam logic [PW:0] MAX_LVL = (PW+1)'(DEPTH);

  rxd_ent_t    mem_q [DEPTH];
  logic [PW:0] wr_q, cmt_q, rd_q, base;

  assign base    = restart_i ? cmt_q : wr_q;
  assign level_o = base - rd_q;
  assign full_o  = (level_o == MAX_LVL);
  assign avail_o = (rd_q != cmt_q);
  assign ent_o   = mem_q[rd_q[PW-1:0]];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[base[PW-1:0]] <= ent_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      cmt_q <= '0;
      rd_q  <= '0;
    end else begin
      if (discard_i)    wr_q <= cmt_q;
      else              wr_q <= base + {{PW{1'b0}}, push_i};
      if (commit_i)     cmt_q <= base + {{PW{1'b0}}, 1'b1};
      rd_q <= rd_q + {{PW{1'b0}}, pop_i};
    end
  end
endmodule

// File: rtl/rxd_ingress.sv
// Frame acceptance, overflow and error handling on the line side.
module rxd_ingress
  import rxd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_en_i,
  input  logic       buf_ok_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_sof_i,
  input  logic       rx_eof_i,
  input  logic       rx_err_i,
  input  logic       full_i,
  output logic       restart_o,
  output logic       discard_o,
  output logic       push_o,
  output logic       commit_o,
  output rxd_ent_t   ent_o
);
  logic in_frame_q, drop_q;
  logic sof_v, start, cont, active, drop_eff, bad_end;

  always_comb begin
    sof_v     = rx_valid_i & rx_sof_i;
    start     = sof_v & rx_en_i & buf_ok_i;
    cont      = rx_valid_i & ~rx_sof_i & in_frame_q;
    active    = start | cont;
    drop_eff  = cont & drop_q;
    bad_end   = rx_eof_i & rx_err_i;
    restart_o = sof_v & in_frame_q;
    push_o    = active & ~drop_eff & ~full_i & ~bad_end;
    commit_o  = push_o & rx_eof_i;
    discard_o = active & rx_eof_i & ~push_o;
    ent_o     = '{last: rx_eof_i, data: rx_data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      drop_q     <= 1'b0;
    end else if (active) begin
      in_frame_q <= ~rx_eof_i;
      drop_q     <= ~rx_eof_i & (drop_eff | full_i);
    end else if (sof_v) begin
      in_frame_q <= 1'b0;
      drop_q     <= 1'b0;
    end
  end
endmodule

// File: rtl/rxd_dma.sv
// Bus master: copies committed frames and follows the buffer link chain.
module rxd_dma
  import rxd_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DATA_OFS = 1,
  parameter int LINK_OFS = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          avail_i,
  input  rxd_ent_t      ent_i,
  input  logic          base_load_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic          gnt_i,
  input  logic [AW-1:0] rdata_i,
  output logic          pop_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] wdata_o,
  output logic          buf_ok_o,
  output logic          irq_set_o
);
  localparam logic [AW-1:0] D_OFS = AW'(DATA_OFS);
  localparam logic [AW-1:0] L_OFS = AW'(LINK_OFS);
  localparam logic [AW-1:0] ONE   = AW'(1);

  dma_st_e       st_q;
  logic [AW-1:0] cur_q, ofs_q;
  logic          ok_q;

  always_comb begin
    req_o     = (st_q != DMA_IDLE);
    we_o      = (st_q == DMA_WR);
    addr_o    = (st_q == DMA_LNK) ? cur_q + L_OFS : cur_q + D_OFS + ofs_q;
    wdata_o   = AW'(ent_i.data);
    pop_o     = (st_q == DMA_WR) & gnt_i;
    irq_set_o = (st_q == DMA_LNK) & gnt_i;
    buf_ok_o  = ok_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= DMA_IDLE;
      cur_q <= '0;
      ofs_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      unique case (st_q)
        DMA_IDLE: begin
          if (base_load_i) begin
            cur_q <= base_addr_i;
            ok_q  <= 1'b1;
            ofs_q <= '0;
          end else if (avail_i && ok_q) begin
            st_q <= DMA_WR;
          end
        end
        DMA_WR: begin
          if (gnt_i) begin
            ofs_q <= ofs_q + ONE;
            if (ent_i.last) st_q <= DMA_LNK;
          end
        end
        DMA_LNK: begin
          if (gnt_i) begin
            cur_q <= rdata_i;
            ok_q  <= (rdata_i != '0);
            ofs_q <= '0;
            st_q  <= DMA_IDLE;
          end
        end
        default: st_q <= DMA_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_chain_dma.sv
module rx_chain_dma
  import rxd_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DEPTH    = 16,
  parameter int DATA_OFS = 1,
  parameter int LINK_OFS = 0,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_en_i,
  input  logic          base_load_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_sof_i,
  input  logic          rx_eof_i,
  input  logic          rx_err_i,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [AW-1:0] bus_wdata_o,
  input  logic [AW-1:0] bus_rdata_i,
  output logic          irq_o,
  input  logic          irq_clr_i
);
  rxd_ent_t    in_ent, out_ent;
  logic        restart, discard, push, commit, pop, avail, full, buf_ok, irq_set;
  logic [PW:0] fifo_level;
  logic        irq_q;

  rxd_ingress u_ing (
    .clk_i, .rst_ni, .rx_en_i,
    .buf_ok_i  (buf_ok),
    .rx_valid_i, .rx_data_i, .rx_sof_i, .rx_eof_i, .rx_err_i,
    .full_i    (full),
    .restart_o (restart),
    .discard_o (discard),
    .push_o    (push),
    .commit_o  (commit),
    .ent_o     (in_ent)
  );

  rxd_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .restart_i (restart),
    .discard_i (discard),
    .push_i    (push),
    .ent_i     (in_ent),
    .commit_i  (commit),
    .pop_i     (pop),
    .ent_o     (out_ent),
    .avail_o   (avail),
    .full_o    (full),
    .level_o   (fifo_level)
  );

  rxd_dma #(.AW(AW), .DATA_OFS(DATA_OFS), .LINK_OFS(LINK_OFS)) u_dma (
    .clk_i, .rst_ni,
    .avail_i     (avail),
    .ent_i       (out_ent),
    .base_load_i, .base_addr_i,
    .gnt_i       (bus_gnt_i),
    .rdata_i     (bus_rdata_i),
    .pop_o       (pop),
    .req_o       (bus_req_o),
    .we_o        (bus_we_o),
    .addr_o      (bus_addr_o),
    .wdata_o     (bus_wdata_o),
    .buf_ok_o    (buf_ok),
    .irq_set_o   (irq_set)
  );

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (irq_set)   irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/rx_chain_dma_chk.sv
module rx_chain_dma_chk #(
  parameter int AW    = 16,
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req_o,
  input logic          bus_gnt_i,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [AW-1:0] bus_wdata_o,
  input logic          irq_o,
  input logic          irq_clr_i,
  input logic [PW:0]   fifo_level
);
  localparam logic [PW:0] MAX_LVL = (PW+1)'(DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_level <= MAX_LVL); // R6
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)
      && $stable(bus_wdata_o)); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(bus_req_o && bus_gnt_i && !bus_we_o)); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o); // R10
  AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i && !(bus_req_o && bus_gnt_i && !bus_we_o) |=> !irq_o); // R10
endmodule

bind rx_chain_dma rx_chain_dma_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_o   (bus_req_o),
  .bus_gnt_i   (bus_gnt_i),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .irq_o       (irq_o),
  .irq_clr_i   (irq_clr_i),
  .fifo_level  (fifo_level)
);

// File: tb/sim_rx_chain_dma.sv
`timescale 1ns/1ps
module sim_rx_chain_dma;
  localparam int AW = 16;
  localparam logic [15:0] SENT = 16'hDEAD;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, rx_en, base_load, rx_valid, rx_sof, rx_eof, rx_err, irq_clr;
  logic [AW-1:0] base_addr, bus_addr, bus_wdata, bus_rdata;
  logic [7:0] rx_data;
  logic bus_req, bus_gnt, bus_we, irq;

  rx_chain_dma u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .base_load_i(base_load),
    .base_addr_i(base_addr), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .rx_err_i(rx_err),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_we_o(bus_we),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .irq_o(irq), .irq_clr_i(irq_clr)
  );

  logic [15:0] mem [0:4095];
  int gnt_mode;  // 0 always, 1 never, 2 random
  always @(posedge clk) if (bus_req && bus_gnt && bus_we) mem[bus_addr[11:0]] <= bus_wdata;
  assign bus_rdata = mem[bus_addr[11:0]];
  always @(negedge clk)
    bus_gnt <= (gnt_mode == 0) ? 1'b1 : (gnt_mode == 1) ? 1'b0 : (($urandom % 4) != 0);

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] fb [0:63];
  logic [15:0] cur_b;

  function automatic logic [15:0] buf_at(int k);
    return 16'h0100 + 16'(k * 32);
  endfunction

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic fill(int off, int len);
    for (int i = 0; i < len; i++) fb[off+i] = 8'($urandom);
  endtask

  // bytes back to back; eof on last unless no_end; optional store-and-forward check
  task automatic send_frame(int len, bit err, int off, bit no_end, bit sf_chk);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (sf_chk) chk(bus_req == 1'b0, "R3 no request before end", bus_req, 0);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = !no_end && (i == len-1);
      rx_err = err && (i == len-1); rx_data = fb[off+i];
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
  endtask

  task automatic check_buf(int len, int off, string r);
    for (int i = 0; i < len; i++)
      chk(mem[12'(cur_b + 16'(1 + i))] == {8'h00, fb[off+i]}, r,
          mem[12'(cur_b + 16'(1 + i))], {8'h00, fb[off+i]});
    chk(mem[12'(cur_b + 16'(1 + len))] == SENT, r, mem[12'(cur_b + 16'(1 + len))], SENT);
    cur_b = mem[12'(cur_b)];
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(irq == 1'b0, "R10 clear", irq, 0);
  endtask

  task automatic expect_good(int len, int off, string r);
    for (int i = 0; i < 300 && !irq; i++) @(negedge clk);
    chk(irq == 1'b1, r, irq, 1);
    check_buf(len, off, r);
    clear_irq();
  endtask

  task automatic expect_drop(string r);
    repeat (40) @(negedge clk);
    chk(irq == 1'b0, r, irq, 0);
    chk(bus_req == 1'b0, r, bus_req, 0);
    chk(mem[12'(cur_b + 16'd1)] == SENT, r, mem[12'(cur_b + 16'd1)], SENT);
  endtask

  task automatic load_base(logic [15:0] a);
    @(negedge clk); base_load = 1'b1; base_addr = a;
    @(negedge clk); base_load = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) mem[i] = SENT;
    for (int k = 0; k < 64; k++) mem[12'(buf_at(k))] = buf_at(k + 1);
    gnt_mode = 0;
    rst_n = 1'b0; rx_en = 1'b0; base_load = 1'b0; base_addr = '0; irq_clr = 1'b0;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0; rx_data = '0;
    cur_b = buf_at(0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R1 irq reset", irq, 0);
    chk(bus_req == 1'b0, "R1 req reset", bus_req, 0);

    // R2: enabled but no buffer, then buffer but disabled
    rx_en = 1'b1; fill(0, 4); send_frame(4, 0, 0, 0, 0); expect_drop("R2 no buffer");
    load_base(buf_at(0));
    rx_en = 1'b0; send_frame(4, 0, 0, 0, 0); expect_drop("R2 disabled");
    rx_en = 1'b1;

    // R12: stray bytes with no start marker
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'(i); rx_eof = (i == 2);
    end
    @(negedge clk); rx_valid = 1'b0; rx_eof = 1'b0;
    expect_drop("R12 stray bytes");

    // R3/R4: exact timing, constant grant, L=5
    fill(0, 5); send_frame(5, 0, 0, 0, 1);
    chk(bus_req == 1'b0, "R3 req after end edge", bus_req, 0);
    repeat (6) @(negedge clk);
    chk(irq == 1'b0, "R4 irq not early", irq, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R4 irq on time", irq, 1);
    expect_good(5, 0, "R3 data placement");

    // R5: errored frame, then good frame in same buffer
    gnt_mode = 2;
    fill(0, 6); send_frame(6, 1, 0, 0, 0); expect_drop("R5 error frame");
    fill(0, 3); send_frame(3, 0, 0, 0, 0); expect_good(3, 0, "R5 buffer reused");

    // R6: overflow vs exactly full
    fill(0, 17); send_frame(17, 0, 0, 0, 0); expect_drop("R6 overflow");
    fill(0, 16); send_frame(16, 0, 0, 0, 0); expect_good(16, 0, "R6 full frame");

    // R11: partial frame abandoned by a new start
    fill(0, 3); send_frame(3, 0, 0, 1, 0);
    fill(8, 4); send_frame(4, 0, 8, 0, 0); expect_good(4, 8, "R11 restart");

    // back-to-back frames into two chained buffers
    fill(0, 5); fill(8, 6);
    send_frame(5, 0, 0, 0, 0); send_frame(6, 0, 8, 0, 0);
    repeat (300) @(negedge clk);
    chk(irq == 1'b1, "R4 irq back to back", irq, 1);
    check_buf(5, 0, "R3 first of pair");
    check_buf(6, 8, "R4 second of pair chained");
    clear_irq();

    // R9: load ignored while busy
    gnt_mode = 1;
    fill(0, 4); send_frame(4, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    load_base(16'h0A00);
    gnt_mode = 2;
    expect_good(4, 0, "R9 busy load ignored");
    fill(0, 2); send_frame(2, 0, 0, 0, 0); expect_good(2, 0, "R9 chain kept");
    chk(mem[12'h A01] == SENT, "R9 loaded addr untouched", mem[12'hA01], SENT);

    // random frames
    for (int n = 0; n < 30; n++) begin
      int len; bit err;
      len = 1 + int'($urandom % 20);
      err = (($urandom % 5) == 0);
      fill(0, len);
      send_frame(len, err, 0, 0, 0);
      if (!err && len <= 16) expect_good(len, 0, "R3 random frame");
      else expect_drop("R5 R6 random drop");
    end

    // R8: end of chain
    mem[12'(cur_b)] = 16'h0000;
    fill(0, 3); send_frame(3, 0, 0, 0, 0); expect_good(3, 0, "R8 last buffer");
    chk(cur_b == 16'h0000, "R8 link zero", cur_b, 0);
    cur_b = 16'h0C00;
    fill(0, 4); send_frame(4, 0, 0, 0, 0); expect_drop("R8 chain ended");
    load_base(16'h0C00);
    send_frame(4, 0, 0, 0, 0); expect_good(4, 0, "R8 resumed after load");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule